// File: doc/BRIEF.md
# Gate-Level Absolute Value Unit

This block returns the magnitude of a signed two's-complement word. Its default width is 16 bits. It is purely combinational: it has no clock and holds no state, so the output follows the input within the same evaluation. It is built only from bitwise logic and one-bit adder cells. No word-level add, subtract, negate or compare operator appears anywhere in its hierarchy.

A small control module reads the sign bit and turns it into a pair of strobes. A datapath module uses those strobes to do two things. First, it conditionally inverts every bit with an XOR mask. Second, it adds the sign as a carry into a ripple chain of full-adder cells.

A non-negative word passes through unchanged. A negative word becomes its two's-complement negation. The most negative word has no positive counterpart, so it maps to itself.

Top module: `absValueUnit`

## Requirements
- R1: The output depends only on the current input. It settles within the same clock period as an input change, with no clock or reset involved.
- R2: When bit 15 of the input is 0, the output equals the input.
- R3: When bit 15 of the input is 1, the output equals the bitwise inverse of the input plus one, modulo 2^16. For every negative input other than 0x8000, bit 15 of the output is 0.
- R4: The input 0x8000 produces 0x8000, with no saturation.
- R5: The input 0x0000 produces 0x0000.
- R6: The input 0xFFFF produces 0x0001.
- R7: The inputs 0x7FFF and 0x8001 both produce 0x7FFF.
- R8: Bit 0 of the output always equals bit 0 of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operandIn | input | 16 | Signed two's-complement value; bit 15 is the sign |
| magnitudeOut | output | 16 | Absolute value of operandIn; 0x8000 maps to itself |

## Verification
The assertions assume the input is a settled two-state word. They do not check the short interval while the ripple carry is still moving through the adder cells. The bench respects this by changing the input only on a rising edge and reading the output on the following falling edge. The stimulus sweeps all 65,536 input values in order. It also repeats the named corner values (zero, all ones, the largest positive value and the two most negative values) as separate checks.

// File: rtl/absPkg.sv
package absPkg;
  parameter int unsigned DefaultWidth = 16;

  typedef struct packed {
    logic invertBits;
    logic addOne;
  } absStrobe_t;
endpackage

// File: rtl/absFullAdder.sv
module absFullAdder (
  input  logic bitA,
  input  logic bitB,
  input  logic carryIn,
  output logic sumOut,
  output logic carryOut
);
  logic halfSum;

  assign halfSum  = bitA ^ bitB;
  assign sumOut   = halfSum ^ carryIn;
  assign carryOut = (bitA & bitB) | (halfSum & carryIn);
endmodule

// File: rtl/absControl.sv
module absControl (
  input  logic              signBit,
  output absPkg::absStrobe_t strobes
);
  always_comb begin
    strobes.invertBits = signBit;
    strobes.addOne     = signBit;
  end
endmodule

// File: rtl/absDatapath.sv
module absDatapath #(
  parameter int unsigned dataWidth = absPkg::DefaultWidth
) (
  input  logic [dataWidth-1:0] operandIn,
  input  absPkg::absStrobe_t   strobes,
  output logic [dataWidth-1:0] resultOut
);
  localparam int unsigned lastBit = dataWidth - 1;

  logic [dataWidth-1:0] maskWord;
  logic [dataWidth-1:0] maskedWord;
  logic [dataWidth-1:0] rippleCarry;

  assign maskWord       = {dataWidth{strobes.invertBits}};
  assign maskedWord     = operandIn ^ maskWord;
  assign rippleCarry[0] = strobes.addOne;

  for (genvar i = 0; i < dataWidth; i++) begin : g_stage
    if (i == lastBit) begin : g_top
      assign resultOut[i] = maskedWord[i] ^ rippleCarry[i];
    end else begin : g_cell
      absFullAdder i_cell (
        .bitA    (maskedWord[i]),
        .bitB    (1'b0),
        .carryIn (rippleCarry[i]),
        .sumOut  (resultOut[i]),
        .carryOut(rippleCarry[i+1])
      );
    end
  end
endmodule

// File: rtl/absValueUnit.sv
module absValueUnit #(
  parameter int unsigned dataWidth = absPkg::DefaultWidth
) (
  input  logic [dataWidth-1:0] operandIn,
  output logic [dataWidth-1:0] magnitudeOut
);
  localparam int unsigned signPos = dataWidth - 1;

  absPkg::absStrobe_t ctrlStrobes;

  absControl i_control (
    .signBit(operandIn[signPos]),
    .strobes(ctrlStrobes)
  );

  absDatapath #(.dataWidth(dataWidth)) i_datapath (
    .operandIn(operandIn),
    .strobes  (ctrlStrobes),
    .resultOut(magnitudeOut)
  );
endmodule

// File: rtl/absValueChecker.sv
module absValueChecker #(
  parameter int unsigned dataWidth = absPkg::DefaultWidth
) (
  input logic [dataWidth-1:0] operandIn,
  input logic [dataWidth-1:0] magnitudeOut
);
  localparam int unsigned signPos = dataWidth - 1;
  localparam logic [dataWidth-1:0] minWord = {1'b1, {(dataWidth-1){1'b0}}};

  logic [dataWidth-1:0] pairSum;

  always_comb begin
    pairSum = magnitudeOut + operandIn;
    if (!operandIn[signPos]) begin
      assert_pass_nonneg_R2: assert (magnitudeOut == operandIn)
        else $error("R2 non-negative input altered");
    end else begin
      assert_negate_sum_R3: assert (pairSum == '0)
        else $error("R3 result is not the negation");
      if (operandIn != minWord) begin
        assert_sign_clear_R3: assert (!magnitudeOut[signPos])
          else $error("R3 result sign set");
      end
    end
    if (operandIn == minWord) begin
      assert_min_wraps_R4: assert (magnitudeOut == minWord)
        else $error("R4 most negative value not wrapped");
    end
    assert_lsb_kept_R8: assert (magnitudeOut[0] == operandIn[0])
      else $error("R8 bit 0 changed");
  end
endmodule

bind absValueUnit absValueChecker #(.dataWidth(dataWidth)) i_checker (
  .operandIn   (operandIn),
  .magnitudeOut(magnitudeOut)
);

// File: tb/test_absValueUnit.sv
`timescale 1ns/1ps
module test_absValueUnit;
  logic        clk = 1'b0;
  logic [15:0] operandIn = 16'h0000;
  logic [15:0] magnitudeOut;
  int          compared = 0;
  int          mismatched = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  absValueUnit #(.dataWidth(16)) i_absValueUnit (
    .operandIn   (operandIn),
    .magnitudeOut(magnitudeOut)
  );

  function automatic logic [15:0] refAbs(input logic [15:0] v);
    logic signed [15:0] s;
    s = v;
    if (s < 0) return 16'(-s);
    return v;
  endfunction

  task automatic checkVal(input string tag, input logic [15:0] got, input logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s in=%h actual=%h expected=%h", tag, operandIn, got, exp);
    end
  endtask

  task automatic applyAndCheck(input string tag, input logic [15:0] v, input logic [15:0] exp);
    @(posedge clk);
    operandIn = v;
    @(negedge clk);
    checkVal(tag, magnitudeOut, exp);
  endtask

  initial begin
    // reset state: zero input gives zero (R5)
    @(negedge clk);
    checkVal("R5", magnitudeOut, 16'h0000);
    applyAndCheck("R6", 16'hFFFF, 16'h0001);
    applyAndCheck("R7", 16'h7FFF, 16'h7FFF);
    applyAndCheck("R7", 16'h8001, 16'h7FFF);
    applyAndCheck("R4", 16'h8000, 16'h8000);
    applyAndCheck("R5", 16'h0000, 16'h0000);
    // R1: output follows a new input within the period, no clock in the design
    @(posedge clk);
    operandIn = 16'hFFF6;
    #1;
    checkVal("R1", magnitudeOut, 16'h000A);
    // exhaustive sweep: R2, R3, R4, R5, R8
    for (int v = 0; v < 65536; v++) begin
      logic [15:0] w;
      logic [15:0] exp;
      string tag;
      w = 16'(v);
      exp = refAbs(w);
      if (w == 16'h0000) tag = "R5";
      else if (w == 16'h8000) tag = "R4";
      else if (w[15]) tag = "R3";
      else tag = "R2";
      @(posedge clk);
      operandIn = w;
      @(negedge clk);
      checkVal(tag, magnitudeOut, exp);
      if (w[15] && w != 16'h8000) checkVal("R3", {15'h0, magnitudeOut[15]}, 16'h0000);
      checkVal("R8", {15'h0, magnitudeOut[0]}, {15'h0, w[0]});
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule